// File: doc/BRIEF.md
# Fan Tachometer Period Capture

This block watches the pulse train from a fan tachometer and measures how long a chosen number of its pulses take. The input is brought into the system clock domain by a two-flop synchronizer. Its rising edges are then detected. A divider makes a measurement tick once every `DIV` system clocks. With a 38.4 MHz clock and the default divide of 38, the tick runs at about 1.01 MHz. For each window, one counter totals the ticks, and a second counter totals the ticks that fall while the tach level is high.

A window spans 1, 2, 4 or 8 tach pulses, chosen by a two-bit log2 code. When a window completes, its results are published to two read words. If the fan stalls, the tick counter reaches its all-ones value. The block then publishes all-ones as the period and raises a sticky overflow flag, which software clears by writing one to it. Software derives speed from the published period. It treats a period of zero or of all-ones as invalid.

The register port is a plain single-cycle write strobe with a combinational read. No data stream crosses the block's edge, so it has no valid/ready handshake and no back-pressure.

Top module: `tach_capture`

## Requirements
- R1: After reset, the control word (offset 0x0) and the high-time word (offset 0x4) both read as zero.
- R2: The tach input passes through two synchronizing flops before its rising edges are detected. The tick runs at clk/DIV, and the divider restarts at each window-opening edge. When a window of N system cycles between its opening and closing detected edges completes, bits 18:0 of the control word hold floor(N/DIV) minus one.
- R3: Bits 26:25 of the control word are a writable, readable window code. Code c selects a window of 2^c tach pulses, so codes 0, 1, 2 and 3 select 1, 2, 4 and 8 pulses.
- R4: Bits 18:0 of the word at offset 0x4 hold the number of ticks in the completed window during which the synchronized tach level was high. That count includes the tick of the closing cycle and excludes the tick of the opening cycle.
- R5: When the tick count of the open window reaches all-ones, the window closes at once. The period field then reads all-ones, bit 24 (overflow) of the control word is set, and the block waits for a fresh rising edge to open a new window.
- R6: The overflow bit is sticky. Writing a control word with bit 24 set clears it, and writing a control word with bit 24 clear leaves it unchanged. If saturation and a clearing write fall in the same cycle, the bit ends set.
- R7: A window that contains fewer than two ticks reports a period of zero.
- R8: A write that changes the window code abandons the open window and waits for a fresh rising edge. The published period and high time keep their values until the next window completes.
- R9: Writes to offset 0x4 or any other offset besides 0x0 change nothing. Reads of offsets other than 0x0 and 0x4 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tach_in | input | 1 | Raw tachometer input, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
Two events can meet in one cycle: the stalled counter saturating and setting overflow, and a software write that clears overflow. The bench sends a single tach pulse. It then counts exactly the cycles from the input edge, through the synchronizer and the divider restart, to the saturating tick, and places a clearing write on that cycle. The result is judged by reading the control word: overflow must still be set, and the period must read all-ones. A following clearing write with no saturation must then clear the flag.

// File: rtl/tach_pkg.sv
package tach_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned FIELD_W = 19;
  localparam int unsigned OVF_BIT = 24;
  localparam int unsigned WIN_LSB = 25;
  localparam logic [2:0]  OFS_CTRL = 3'h0;
  localparam logic [2:0]  OFS_HIGH = 3'h4;

  typedef logic [1:0] win_code_t;

  // Number of tach pulses per window for a log2 code.
  function automatic logic [3:0] win_pulses(win_code_t code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tach_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], tach_in};
  end

  assign level = sh[STAGES-1];
  assign rise  = sh[STAGES-1] & ~sh[STAGES];

  // R2: one detected edge per synchronized transition
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tach_tick_gen.sv
module tach_tick_gen #(
  parameter int unsigned DIV = 38
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (tick)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R2: ticks are never back to back when dividing
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && DIV > 1) |=> !tick);
endmodule

// File: rtl/tach_window_meas.sv
module tach_window_meas
  import tach_pkg::*;
#(
  parameter int unsigned PW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          level,
  input  logic          rise,
  input  logic          restart,
  input  win_code_t     win_code,
  output logic          div_restart,
  output logic          cap_evt,
  output logic          sat_evt,
  output logic [PW-1:0] cap_period,
  output logic [PW-1:0] cap_high
);
  localparam logic [PW-1:0] CNT_MAX = {PW{1'b1}};

  logic          running;
  logic [3:0]    pulses;
  logic [PW-1:0] ticks, highs, ticks_nx, highs_nx;
  logic          done_evt, start_evt;

  always_comb begin
    ticks_nx = ticks;
    highs_nx = highs;
    if (running && tick && ticks != CNT_MAX)          ticks_nx = ticks + 1'b1;
    if (running && tick && level && highs != CNT_MAX) highs_nx = highs + 1'b1;
  end

  assign sat_evt   = running && tick && (ticks == CNT_MAX - 1'b1) && !restart;
  assign done_evt  = running && rise && !sat_evt && !restart &&
                     ((pulses + 4'd1) == win_pulses(win_code));
  assign cap_evt   = sat_evt | done_evt;
  assign start_evt = rise && !restart && !sat_evt && (!running || done_evt);
  assign div_restart = start_evt;

  assign cap_period = sat_evt ? CNT_MAX :
                      (ticks_nx == '0) ? '0 : ticks_nx - 1'b1;
  assign cap_high   = highs_nx;

  always_ff @(posedge clk) begin
    if (!rst_n || restart || sat_evt) begin
      running <= 1'b0;
      pulses  <= '0;
      ticks   <= '0;
      highs   <= '0;
    end else if (start_evt) begin
      running <= 1'b1;
      pulses  <= '0;
      ticks   <= '0;
      highs   <= '0;
    end else begin
      if (rise) pulses <= pulses + 1'b1;
      ticks <= ticks_nx;
      highs <= highs_nx;
    end
  end

  // R4: high ticks never exceed total ticks in the open window
  a_r4_high_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    highs <= ticks);
  // R5: saturation closes the window and re-arms
  a_r5_sat_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> !running);
  // R8: a window code change abandons the open window
  a_r8_restart_idle: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !running);
endmodule

// File: rtl/tach_capture.sv
module tach_capture
  import tach_pkg::*;
#(
  parameter int unsigned DIV = 38,
  parameter int unsigned PW  = FIELD_W
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tach_in,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic          level, rise, tick, div_restart;
  logic          cap_evt, sat_evt;
  logic [PW-1:0] cap_period, cap_high;
  logic [PW-1:0] period_q, high_q;
  win_code_t     win_q, win_wr;
  logic          ovf_q;
  logic          wr_ctrl, win_change, ovf_clr;
  logic          unused_wdata;

  assign wr_ctrl    = reg_wr && (reg_addr == OFS_CTRL);
  assign win_wr     = reg_wdata[WIN_LSB +: 2];
  assign win_change = wr_ctrl && (win_wr != win_q);
  assign ovf_clr    = wr_ctrl && reg_wdata[OVF_BIT];
  assign unused_wdata = ^{reg_wdata[31:27], reg_wdata[23:0]};

  tach_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .level(level), .rise(rise)
  );

  tach_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(div_restart), .tick(tick)
  );

  tach_window_meas #(.PW(PW)) u_meas (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level), .rise(rise),
    .restart(win_change), .win_code(win_q), .div_restart(div_restart),
    .cap_evt(cap_evt), .sat_evt(sat_evt),
    .cap_period(cap_period), .cap_high(cap_high)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      high_q   <= '0;
      win_q    <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (cap_evt) begin
        period_q <= cap_period;
        high_q   <= cap_high;
      end
      if (wr_ctrl) win_q <= win_wr;
      if (sat_evt)      ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CTRL: begin
        reg_rdata[PW-1:0]        = period_q;
        reg_rdata[OVF_BIT]       = ovf_q;
        reg_rdata[WIN_LSB +: 2]  = win_q;
      end
      OFS_HIGH: reg_rdata[PW-1:0] = high_q;
      default:  reg_rdata = '0;
    endcase
  end

  // R6: saturation wins over a same-cycle clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> ovf_q);
  // R6: clearing write without saturation clears
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !sat_evt) |=> !ovf_q);
  // R6: flag is sticky when not cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
  // R5: saturation publishes all-ones
  a_r5_sat_value: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> (period_q == {PW{1'b1}}));
  // R8: results hold between completed windows
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> ($stable(period_q) && $stable(high_q)));
  // R3: window code follows a control write
  a_r3_win_update: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> (win_q == $past(reg_wdata[WIN_LSB +: 2])));
endmodule

// File: tb/tach_capture_bench.sv
module tach_capture_bench;
  localparam int DIV = 4;
  localparam int PW  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tach_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tach_capture #(.DIV(DIV), .PW(PW)) u_tach_capture (
    .clk(clk), .rst_n(rst_n), .tach_in(tach_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr    = 1'b1;
    step(1);
    reg_wr    = 1'b0;
    reg_wdata = '0;
  endtask

  function automatic logic [31:0] ctrl_word(logic [1:0] code, logic clr);
    return {5'b0, code, clr, 24'b0};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; tach_in = 1'b0; reg_wr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
  endtask

  task automatic wave(int p, int h, int n);
    for (int i = 0; i < n; i++) begin
      tach_in = 1'b1; step(h);
      tach_in = 1'b0; step(p - h);
    end
  endtask

  // R2/R3/R4: steady waveform, window of 2^code pulses
  task automatic t_measure(string tag, logic [1:0] code, int p, int h, int n,
                           int exp_per, int exp_high);
    logic [31:0] v;
    do_reset();
    wr(3'h0, ctrl_word(code, 1'b0));
    rd(3'h0, v);
    check("R3", {tag, " window code readback"}, (v >> 25) & 32'h3, 32'(code));
    wave(p, h, n);
    step(20);
    rd(3'h0, v);
    check("R2", {tag, " period"}, v & 32'h7FFFF, 32'(exp_per));
    rd(3'h4, v);
    check("R4", {tag, " high time"}, v & 32'h7FFFF, 32'(exp_high));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    rd(3'h0, v); check("R1", "control word after reset", v, 32'h0);
    rd(3'h4, v); check("R1", "high word after reset", v, 32'h0);
  endtask

  task automatic t_short();
    logic [31:0] v;
    do_reset();
    wave(4, 2, 4);
    step(3);
    rd(3'h0, v);
    check("R7", "single-tick window period", v & 32'h7FFFF, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    do_reset();
    step(4);
    tach_in = 1'b1;          // edge E0
    step(8);
    tach_in = 1'b0;
    step(1014);
    wr(3'h0, ctrl_word(2'd0, 1'b1));   // lands on the saturating cycle
    rd(3'h0, v);
    check("R6", "set wins over same-cycle clear", (v >> 24) & 32'h1, 32'h1);
    check("R5", "saturated period all-ones", v & 32'h7FFFF, 32'hFF);
    rd(3'h4, v);
    check("R5", "high time at saturation", v & 32'h7FFFF, 32'h1);
    wr(3'h0, ctrl_word(2'd0, 1'b0));
    rd(3'h0, v);
    check("R6", "writing zero keeps overflow", (v >> 24) & 32'h1, 32'h1);
    wr(3'h0, ctrl_word(2'd0, 1'b1));
    rd(3'h0, v);
    check("R6", "writing one clears overflow", (v >> 24) & 32'h1, 32'h0);
    check("R6", "period kept after clear", v & 32'h7FFFF, 32'hFF);
    wave(40, 12, 3);
    step(5);
    rd(3'h0, v);
    check("R5", "re-armed measurement after stall", v & 32'h7FFFF, 32'd9);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    do_reset();
    wr(3'h0, ctrl_word(2'd3, 1'b0));
    wave(40, 12, 17);
    wave(20, 8, 4);
    wr(3'h0, ctrl_word(2'd1, 1'b0));
    step(3);
    rd(3'h0, v);
    check("R8", "period held across code change", v & 32'h7FFFF, 32'd79);
    rd(3'h4, v);
    check("R8", "high held across code change", v & 32'h7FFFF, 32'd24);
    wave(20, 8, 5);
    step(10);
    rd(3'h0, v);
    check("R8", "period after restart with new window", v & 32'h7FFFF, 32'd9);
    rd(3'h4, v);
    check("R8", "high after restart with new window", v & 32'h7FFFF, 32'd4);
  endtask

  task automatic t_ignored();
    logic [31:0] v;
    do_reset();
    wr(3'h0, ctrl_word(2'd1, 1'b0));
    wave(40, 12, 5);
    step(5);
    wr(3'h4, 32'hFFFF_FFFF);
    wr(3'h2, 32'hFFFF_FFFF);
    rd(3'h4, v);
    check("R9", "high word after ignored writes", v & 32'h7FFFF, 32'd6);
    rd(3'h0, v);
    check("R9", "control word after ignored writes", v, {5'b0, 2'd1, 1'b0, 24'd19});
    rd(3'h2, v);
    check("R9", "unused offset reads zero", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_measure("w8", 2'd3, 40, 12, 17, 79, 24);
    t_measure("w2", 2'd1, 40, 12, 5, 19, 6);
    t_measure("w1", 2'd0, 100, 20, 3, 24, 5);
    t_measure("w4", 2'd2, 24, 8, 9, 23, 8);
    t_short();
    t_overflow();
    t_restart();
    t_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule